// File: doc/BRIEF.md
# Two-Wire Configuration Register Target

This block is a byte-oriented two-wire (I2C) target that holds the configuration of a dual-output video port switch. A host uses it to set the standby control, the output port choice, the port priority scheme, the input type, the receive equalization and timer options, the transmit termination, pre-emphasis, swing and slew options, and the hot-plug and DDC handling options. The block decodes these register fields onto dedicated output pins. It also reports the live hot-plug levels of both output ports and returns a fixed identifier byte.

Both bus lines are sampled on the system clock. Each line passes through a synchronizer and a glitch filter, and edge detection is done on the filtered levels. The target answers at a 7-bit address made of a fixed pattern and two bits taken from strap inputs. It pulls SDA low through an output-enable and never drives it high. In a write, the first data byte loads an index pointer, and each later byte writes the indexed register and advances the pointer. A read starts at the current pointer and advances it after every byte. The read continues while the host acknowledges and ends at the host's not-acknowledge.

Top module: `cfg_i2c_regbank`

## Requirements
- R1: The target responds only to the address byte whose seven upper bits are 1,0,1,1,S1,S0,1. S1 is addr_strap[1] and S0 is addr_strap[0]. The least significant bit is the direction (1 = read, 0 = write). For any other address it leaves SDA released for the rest of that transfer.
- R2: After a matching address byte, and after every data byte of a write, the target pulls SDA low for the acknowledge clock.
- R3: In a write, the first data byte sets the index pointer. Each later byte is stored into the register at the pointer, and the pointer then increments by one.
- R4: A read returns the register at the current pointer and increments the pointer after each byte. It continues with the next register after a host acknowledge. After a host not-acknowledge it stops driving until the next start.
- R5: After reset, registers 0, 1, 2 and the upper nibble of register 4 hold zero, and every configuration output is zero.
- R6: Register 0 maps bit 7 to standby, bits 6:5 to port_sel, bits 4:2 to prio_sel and bit 1 to input_kind. Bit 0 always reads 0.
- R7: Register 1 maps bits 7:5 to eq_code, bits 4:3 to tmr_src, bit 2 to t3_sel, bit 1 to t4_sel and bit 0 to t1_sel. All bits read back as written.
- R8: Register 2 maps bit 7 to term_mode, bits 6:4 to preemph, bits 3:2 to swing and bit 1 to slew_opt. Bit 0 always reads 0.
- R9: Register 3 always reads 0x51, and writes to it are acknowledged but have no effect.
- R10: Register 4 maps bit 7 to hp_invert, bit 6 to ddc_passive and bit 5 to imm_switch, and bit 4 is a spare read/write bit. On a read, bit 3 returns hp2_lvl and bit 1 returns hp1_lvl, while bits 2 and 0 return 0. Writes to bits 3:0 are ignored.
- R11: Writes to indices above 4 are acknowledged and ignored, and reads of those indices return 0x00.
- R12: A start or stop seen in the middle of a byte abandons that byte without storing it. A start always begins a new address phase.
- R13: The target only asserts its SDA pull-down while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_strap | input | 2 | Strap bits of the target address (bit 1 above bit 0) |
| hp1_lvl | input | 1 | Hot-plug level of port 1 |
| hp2_lvl | input | 1 | Hot-plug level of port 2 |
| standby | output | 1 | Standby request |
| port_sel | output | 2 | Output port choice code |
| prio_sel | output | 3 | Port priority code |
| input_kind | output | 1 | Input type select |
| eq_code | output | 3 | Equalization step code |
| tmr_src | output | 2 | Timer source option |
| t3_sel | output | 1 | Switch-gap timer option |
| t4_sel | output | 1 | Power-down timer option |
| t1_sel | output | 1 | Interrupt pulse width option |
| term_mode | output | 1 | 0 open drain, 1 double termination |
| preemph | output | 3 | Pre-emphasis code |
| swing | output | 2 | Output swing code |
| slew_opt | output | 1 | Slew option |
| hp_invert | output | 1 | Hot-plug output inversion |
| ddc_passive | output | 1 | DDC passive mode select |
| imm_switch | output | 1 | Immediate manual switch |

## Verification
The assertions check several rules on every cycle. SDA stays released while the engine is idle. The decoded configuration never moves without a register write strobe. A write strobe aimed above index 4 leaves the configuration untouched. The pull-down only rises while the filtered SCL is low. Everything that depends on byte content has to come from the bench's scenarios: address matching against the straps, pointer loading and wrap-around across bursts, masking of reserved and read-only bits, the identifier and live hot-plug bits in read data, and the abandonment of bytes cut off by a start or stop.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  localparam logic [3:0] DEV_ADDR_HI  = 4'b1011;
  localparam logic [7:0] DEV_ID_BYTE  = 8'h51;
  localparam int unsigned LAST_IDX    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_WDATA,
    ST_ACK_W,
    ST_RDATA,
    ST_ACK_R
  } tgt_state_e;

  typedef struct packed {
    logic       standby;
    logic [1:0] port_sel;
    logic [2:0] prio_sel;
    logic       input_kind;
    logic [2:0] eq_code;
    logic [1:0] tmr_src;
    logic       t3_sel;
    logic       t4_sel;
    logic       t1_sel;
    logic       term_mode;
    logic [2:0] preemph;
    logic [1:0] swing;
    logic       slew_opt;
    logic       hp_invert;
    logic       ddc_passive;
    logic       imm_switch;
  } cfg_fields_t;

endpackage

// File: rtl/cfg_line_filter.sv
module cfg_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   filt_q;
  logic                   filt_n;

  always_comb begin
    filt_n = filt_q;
    if (&hist_q)       filt_n = 1'b1;
    else if (~|hist_q) filt_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      filt_q <= filt_n;
    end
  end

  assign filt = filt_q;

endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_f,
  input  logic             sda_f,
  input  logic [1:0]       addr_strap,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] ptr,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe,
  output tgt_state_e       state
);

  localparam int unsigned CNT_W = 4;
  localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);

  logic             scl_q, sda_q;
  tgt_state_e       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [7:0]       sh_q, sh_n;
  logic [IDX_W-1:0] ptr_q, ptr_n;
  logic             first_q, first_n;
  logic             rw_q, rw_n;
  logic             nack_q, nack_n;
  logic             oe_q, oe_n;

  logic       scl_rise, scl_fall, start_ev, stop_ev;
  logic [6:0] dev_addr;

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
  assign dev_addr = {DEV_ADDR_HI, addr_strap[1], addr_strap[0], 1'b1};

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    ptr_n   = ptr_q;
    first_n = first_q;
    rw_n    = rw_q;
    nack_n  = nack_q;
    oe_n    = oe_q;
    wr_en   = 1'b0;
    if (start_ev) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (stop_ev) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            sh_n  = {sh_q[6:0], sda_f};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == BYTE_BITS) begin
            if (sh_q[7:1] == dev_addr) begin
              oe_n = 1'b1;
              rw_n = sh_q[0];
              st_n = ST_ACK_ADDR;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_ACK_ADDR: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw_q) begin
              sh_n = rd_data;
              oe_n = ~rd_data[7];
              st_n = ST_RDATA;
            end else begin
              oe_n    = 1'b0;
              first_n = 1'b1;
              st_n    = ST_WDATA;
            end
          end
        end
        ST_WDATA: begin
          if (scl_rise) begin
            sh_n  = {sh_q[6:0], sda_f};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == BYTE_BITS) begin
            oe_n  = 1'b1;
            cnt_n = '0;
            st_n  = ST_ACK_W;
            if (first_q) begin
              ptr_n   = IDX_W'(sh_q);
              first_n = 1'b0;
            end else begin
              wr_en = 1'b1;
              ptr_n = ptr_q + 1'b1;
            end
          end
        end
        ST_ACK_W: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            cnt_n = '0;
            st_n  = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == BYTE_BITS) begin
              oe_n  = 1'b0;
              ptr_n = ptr_q + 1'b1;
              st_n  = ST_ACK_R;
            end else begin
              sh_n = {sh_q[6:0], 1'b0};
              oe_n = ~sh_q[6];
            end
          end
        end
        ST_ACK_R: begin
          if (scl_rise) begin
            nack_n = sda_f;
          end else if (scl_fall) begin
            if (nack_q) begin
              st_n = ST_IDLE;
            end else begin
              sh_n  = rd_data;
              oe_n  = ~rd_data[7];
              cnt_n = '0;
              st_n  = ST_RDATA;
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      first_q <= 1'b0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      scl_q   <= scl_f;
      sda_q   <= sda_f;
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      ptr_q   <= ptr_n;
      first_q <= first_n;
      rw_q    <= rw_n;
      nack_q  <= nack_n;
      oe_q    <= oe_n;
    end
  end

  assign ptr     = ptr_q;
  assign wr_idx  = ptr_q;
  assign wr_data = sh_q;
  assign sda_oe  = oe_q;
  assign state   = st_q;

endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             hp1_lvl,
  input  logic             hp2_lvl,
  output logic [7:0]       rd_data,
  output cfg_fields_t      cfg
);

  localparam int unsigned NUM_RW = 3;
  localparam logic [NUM_RW-1:0][7:0] WMASK = {8'hFE, 8'hFF, 8'hFE};
  localparam logic [IDX_W-1:0] IDX_ID  = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_HPS = IDX_W'(LAST_IDX);

  logic [7:0] rw_q [NUM_RW];
  logic [3:0] hps_hi_q;
  logic       hps_hit;

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rw_q[g] <= '0;
      else if (hit) rw_q[g] <= wr_data & WMASK[g];
    end
  end

  assign hps_hit = wr_en && (wr_idx == IDX_HPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hps_hi_q <= '0;
    else if (hps_hit) hps_hi_q <= wr_data[7:4];
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_idx < IDX_W'(NUM_RW))  rd_data = rw_q[rd_idx[1:0]];
    else if (rd_idx == IDX_ID)    rd_data = DEV_ID_BYTE;
    else if (rd_idx == IDX_HPS)   rd_data = {hps_hi_q, hp2_lvl, 1'b0, hp1_lvl, 1'b0};
  end

  always_comb begin
    cfg.standby     = rw_q[0][7];
    cfg.port_sel    = rw_q[0][6:5];
    cfg.prio_sel    = rw_q[0][4:2];
    cfg.input_kind  = rw_q[0][1];
    cfg.eq_code     = rw_q[1][7:5];
    cfg.tmr_src     = rw_q[1][4:3];
    cfg.t3_sel      = rw_q[1][2];
    cfg.t4_sel      = rw_q[1][1];
    cfg.t1_sel      = rw_q[1][0];
    cfg.term_mode   = rw_q[2][7];
    cfg.preemph     = rw_q[2][6:4];
    cfg.swing       = rw_q[2][3:2];
    cfg.slew_opt    = rw_q[2][1];
    cfg.hp_invert   = hps_hi_q[3];
    cfg.ddc_passive = hps_hi_q[2];
    cfg.imm_switch  = hps_hi_q[1];
  end

endmodule

// File: rtl/cfg_i2c_regbank.sv
module cfg_i2c_regbank
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned FILT_LEN    = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDX_W       = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_strap,
  input  logic       hp1_lvl,
  input  logic       hp2_lvl,
  output logic       standby,
  output logic [1:0] port_sel,
  output logic [2:0] prio_sel,
  output logic       input_kind,
  output logic [2:0] eq_code,
  output logic [1:0] tmr_src,
  output logic       t3_sel,
  output logic       t4_sel,
  output logic       t1_sel,
  output logic       term_mode,
  output logic [2:0] preemph,
  output logic [1:0] swing,
  output logic       slew_opt,
  output logic       hp_invert,
  output logic       ddc_passive,
  output logic       imm_switch
);

  localparam int unsigned NUM_LINES = 2;

  logic                 rst_meta_q, core_rst_n;
  logic [NUM_LINES-1:0] line_raw, line_filt;
  logic                 scl_f, sda_f;
  logic [IDX_W-1:0]     ptr, wr_idx;
  logic                 wr_en;
  logic [7:0]           wr_data, rd_data;
  tgt_state_e           state;
  cfg_fields_t          cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      core_rst_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      core_rst_n <= rst_meta_q;
    end
  end

  assign line_raw = {sda_i, scl_i};

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    cfg_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk  (clk),
      .rst_n(core_rst_n),
      .raw  (line_raw[l]),
      .filt (line_filt[l])
    );
  end

  assign scl_f = line_filt[0];
  assign sda_f = line_filt[1];

  cfg_i2c_engine #(.IDX_W(IDX_W)) u_eng (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .addr_strap(addr_strap),
    .rd_data   (rd_data),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe),
    .state     (state)
  );

  cfg_reg_file #(.IDX_W(IDX_W)) u_regs (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .rd_idx (ptr),
    .hp1_lvl(hp1_lvl),
    .hp2_lvl(hp2_lvl),
    .rd_data(rd_data),
    .cfg    (cfg)
  );

  assign standby     = cfg.standby;
  assign port_sel    = cfg.port_sel;
  assign prio_sel    = cfg.prio_sel;
  assign input_kind  = cfg.input_kind;
  assign eq_code     = cfg.eq_code;
  assign tmr_src     = cfg.tmr_src;
  assign t3_sel      = cfg.t3_sel;
  assign t4_sel      = cfg.t4_sel;
  assign t1_sel      = cfg.t1_sel;
  assign term_mode   = cfg.term_mode;
  assign preemph     = cfg.preemph;
  assign swing       = cfg.swing;
  assign slew_opt    = cfg.slew_opt;
  assign hp_invert   = cfg.hp_invert;
  assign ddc_passive = cfg.ddc_passive;
  assign imm_switch  = cfg.imm_switch;

endmodule

// File: rtl/cfg_i2c_regbank_chk.sv
module cfg_i2c_regbank_chk
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_f,
  input logic             sda_oe,
  input tgt_state_e       state,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input cfg_fields_t      cfg
);

  // R1: an idle engine never pulls the data line
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R3: configuration changes only through a register write strobe
  p_cfg_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg));

  // R11: strobes beyond the last index leave the configuration alone
  p_high_index_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx > IDX_W'(LAST_IDX)) |=> $stable(cfg));

  // R13: pull-down is only switched on while the clock line is low
  p_oe_rise_scl_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

endmodule

bind cfg_i2c_regbank cfg_i2c_regbank_chk #(.IDX_W(IDX_W)) u_chk (
  .clk   (clk),
  .rst_n (core_rst_n),
  .scl_f (scl_f),
  .sda_oe(sda_oe),
  .state (state),
  .wr_en (wr_en),
  .wr_idx(wr_idx),
  .cfg   (cfg)
);

// File: tb/sim_cfg_i2c_regbank.sv
module sim_cfg_i2c_regbank;

  localparam int CLK_PER  = 10;
  localparam int Q        = 8;
  localparam int WDOG_MAX = 190000;
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [6:0] MY_ADDR = {4'b1011, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic hp1 = 1'b0, hp2 = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  logic       standby, input_kind, t3_sel, t4_sel, t1_sel, term_mode, slew_opt;
  logic       hp_invert, ddc_passive, imm_switch;
  logic [1:0] port_sel, tmr_src, swing;
  logic [2:0] prio_sel, eq_code, preemph;

  int checks = 0;
  int errors = 0;
  int r13_viol = 0;
  bit done = 0;
  logic [7:0] m [5];

  always #(CLK_PER/2) clk = ~clk;

  cfg_i2c_regbank u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_strap(STRAP), .hp1_lvl(hp1), .hp2_lvl(hp2),
    .standby(standby), .port_sel(port_sel), .prio_sel(prio_sel), .input_kind(input_kind),
    .eq_code(eq_code), .tmr_src(tmr_src), .t3_sel(t3_sel), .t4_sel(t4_sel), .t1_sel(t1_sel),
    .term_mode(term_mode), .preemph(preemph), .swing(swing), .slew_opt(slew_opt),
    .hp_invert(hp_invert), .ddc_passive(ddc_passive), .imm_switch(imm_switch)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wmask(input int i);
    case (i)
      0: return 8'hFE;
      1: return 8'hFF;
      2: return 8'hFE;
      4: return 8'hF0;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input int i);
    case (i)
      0, 1, 2: return m[i];
      3: return 8'h51;
      4: return m[4] | {4'b0, hp2, 1'b0, hp1, 1'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic q_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q_wait(Q);
    scl_m = 1'b1; q_wait(Q);
    sda_m = 1'b0; q_wait(Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    q_wait(Q); sda_m = 1'b0;
    q_wait(Q); scl_m = 1'b1;
    q_wait(Q); sda_m = 1'b1;
    q_wait(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      q_wait(Q); sda_m = v[i];
      q_wait(Q); scl_m = 1'b1;
      q_wait(2*Q); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] v, output logic nack);
    send_bits(v, 8);
    q_wait(Q); sda_m = 1'b1;
    q_wait(Q); scl_m = 1'b1;
    q_wait(Q); nack = sda_line;
    q_wait(Q); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic give_nack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      q_wait(Q); sda_m = 1'b1;
      q_wait(Q); scl_m = 1'b1;
      q_wait(Q); v[i] = sda_line;
      q_wait(Q); scl_m = 1'b0;
    end
    q_wait(Q); sda_m = give_nack;
    q_wait(Q); scl_m = 1'b1;
    q_wait(2*Q); scl_m = 1'b0;
  endtask

  task automatic reg_write(input int idx, input logic [7:0] d [], input int n);
    logic nk;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, nk); chk(nk == 1'b0, "R2 addr ack", nk, 0);
    send_byte(8'(idx), nk);         chk(nk == 1'b0, "R2 index ack", nk, 0);
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], nk);
      chk(nk == 1'b0, "R2 data ack", nk, 0);
      if (idx + k <= 4) m[idx + k] = d[k] & wmask(idx + k);
    end
    bus_stop();
  endtask

  task automatic set_index(input int idx);
    logic nk;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, nk);
    send_byte(8'(idx), nk);
    bus_stop();
  endtask

  task automatic read_check(input int idx, input int n, input string req);
    logic nk;
    logic [7:0] v;
    set_index(idx);
    bus_start();
    send_byte({MY_ADDR, 1'b1}, nk); chk(nk == 1'b0, "R2 read addr ack", nk, 0);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, v);
      chk(v == exp_rd((idx + k) % 256), req, v, exp_rd((idx + k) % 256));
    end
    bus_stop();
  endtask

  task automatic field_check();
    chk({standby, port_sel, prio_sel, input_kind, 1'b0} == m[0], "R6 reg0 fields",
        {standby, port_sel, prio_sel, input_kind, 1'b0}, m[0]);
    chk({eq_code, tmr_src, t3_sel, t4_sel, t1_sel} == m[1], "R7 reg1 fields",
        {eq_code, tmr_src, t3_sel, t4_sel, t1_sel}, m[1]);
    chk({term_mode, preemph, swing, slew_opt, 1'b0} == m[2], "R8 reg2 fields",
        {term_mode, preemph, swing, slew_opt, 1'b0}, m[2]);
    chk({hp_invert, ddc_passive, imm_switch} == m[4][7:5], "R10 reg4 fields",
        {hp_invert, ddc_passive, imm_switch}, m[4][7:5]);
  endtask

  // R13 monitor: pull-down may only start while the clock line is low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (sda_oe && !oe_prev && scl_m) r13_viol++;
    oe_prev <= sda_oe;
  end

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG_MAX) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WDOG_MAX);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : main
    logic nk;
    logic [7:0] v;
    logic [7:0] d [];
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 5; i++) m[i] = 8'h00;
    q_wait(6);
    rst_n = 1'b1;
    q_wait(10);

    // R5: reset state
    field_check();
    chk(sda_oe == 1'b0, "R5 released after reset", sda_oe, 0);
    read_check(0, 5, "R5 reset readback");

    // R1: foreign addresses get no acknowledge
    bus_start(); send_byte({4'b1011, 2'b01, 1'b1, 1'b0}, nk); bus_stop();
    chk(nk == 1'b1, "R1 strap mismatch nack", nk, 1);
    bus_start(); send_byte({4'b1011, STRAP, 1'b0, 1'b0}, nk); bus_stop();
    chk(nk == 1'b1, "R1 fixed bit mismatch nack", nk, 1);
    bus_start(); send_byte(8'h50, nk); bus_stop();
    chk(nk == 1'b1, "R1 other address nack", nk, 1);

    // R3, R6-R8: directed burst write across regs 0..2, R9 id write ignored
    d = new[5];
    d[0] = 8'hFF; d[1] = 8'hA5; d[2] = 8'h5B; d[3] = 8'h00; d[4] = 8'hFF;
    reg_write(0, d, 5);
    field_check();
    read_check(0, 5, "R3 burst readback");
    read_check(3, 1, "R9 identifier");

    // R10: live hot-plug bits and masked low nibble
    hp1 = 1'b1; hp2 = 1'b0; q_wait(4);
    read_check(4, 1, "R10 status hp1");
    hp1 = 1'b0; hp2 = 1'b1; q_wait(4);
    read_check(4, 1, "R10 status hp2");

    // R11: high index write ignored, reads zero, pointer wraps
    d[0] = 8'hC3; d[1] = 8'h3C;
    reg_write(7, d, 2);
    field_check();
    read_check(6, 2, "R11 unmapped reads zero");
    read_check(255, 2, "R4 pointer wrap");

    // R12: stop in mid-address, then a valid write still works
    bus_start(); send_bits({MY_ADDR, 1'b0}, 4); bus_stop();
    d[0] = 8'h6E;
    reg_write(1, d, 1);
    field_check();
    // R12: restart in mid-data byte discards the partial byte
    bus_start();
    send_byte({MY_ADDR, 1'b0}, nk);
    send_byte(8'h01, nk);
    send_bits(8'h00, 3);
    bus_start();
    send_byte({MY_ADDR, 1'b1}, nk);
    chk(nk == 1'b0, "R12 restart addr ack", nk, 0);
    recv_byte(1'b1, v);
    chk(v == m[1], "R12 partial byte discarded", v, m[1]);
    q_wait(2*Q);
    chk(sda_oe == 1'b0, "R4 released after host nack", sda_oe, 0);
    bus_stop();
    field_check();

    // Random bursts
    for (int it = 0; it < 20; it++) begin
      int idx, n;
      idx = $urandom % 6;
      n = 1 + $urandom % 5;
      d = new[n];
      for (int k = 0; k < n; k++) d[k] = 8'($urandom);
      reg_write(idx, d, n);
      hp1 = 1'($urandom); hp2 = 1'($urandom);
      q_wait(4);
      read_check(0, 6, "R4 random burst readback");
      field_check();
    end

    chk(r13_viol == 0, "R13 pull-down only with clock low", r13_viol, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule